// File: doc/BRIEF.md
# Signed Halfword Register-Offset Load Unit

This unit carries out one load of a signed 16-bit value for a processor pipeline, given control fields that have already been decoded. The fields name the destination, base and index registers. They also carry a pre/post-index flag, an add/subtract flag, a writeback flag and a 2-bit shift amount. A variant selector picks the full form or one of two narrow forms. The unit reads the base and index values through two combinational register-file read ports. It scales the index value and adds it to the base or subtracts it. It then issues a single halfword read on a valid/ready memory request port.

When the 16-bit response arrives, the unit sign-extends it to 32 bits and writes it to the destination register. In the same cycle, and only when writeback applies, it writes the offset address back to the base register. Both writes use their own write ports. A single-cycle done pulse closes every operation. The same pulse carries a redirect flag when the field combination belongs to the unprivileged-load variant. It carries an unpredictable flag when the register choice is not allowed.

Top module: `hsload_unit`

## Requirements
- R1: The index value is shifted left by the 2-bit shift field (0, 1, 2 or 3 bit positions) before it is added or subtracted.
- R2: The offset address is base + shifted index when the add flag is 1 and base - shifted index when it is 0, computed modulo 2^32.
- R3: The memory request address is the offset address when the pre-index flag is 1 and the unmodified base value when it is 0.
- R4: Writeback applies when the pre-index flag is 0 or the writeback flag is 1. The base write port then writes the offset address to the base register in the same cycle as the destination write.
- R5: The destination write carries the returned halfword sign-extended to 32 bits: bits 31:16 equal bit 15.
- R6: In the full variant (variant 2'b00), pre-index 0 together with writeback 1 is not executed. There is no memory request and no register write, and done rises one cycle after start with redirect high.
- R7: Destination register 15 or index register 15 sets the unpredictable flag on the done pulse.
- R8: When writeback applies and the base is register 15 or equals the destination, the unpredictable flag is set. When the base equals the destination, the base write is suppressed and the destination receives the loaded data.
- R9: The compact variant (2'b01) forces add=1, pre-index=1, writeback=0 and shift=0. The wide variant (2'b10) forces the same flags but uses the shift field. Neither variant ever redirects.
- R10: The memory request is raised in the cycle after start. It stays valid with a stable address until ready is seen, and exactly one request is made per load.
- R11: Done is high for exactly one cycle, in the cycle after the response is accepted. The write enables are high only during done.
- R12: An odd (unaligned) address is passed to memory unchanged, and the address wraps around past 2^32 - 1 without a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| start | input | 1 | Begin an operation (taken only while idle) |
| variant | input | 2 | 00 full, 01 compact, 10 wide, 11 treated as full |
| dst_reg | input | 4 | Destination register number |
| base_reg | input | 4 | Base register number |
| idx_reg | input | 4 | Index register number |
| pre_idx | input | 1 | 1: address uses the offset; 0: address uses the base |
| add_sel | input | 1 | 1: add the scaled index; 0: subtract it |
| wb_sel | input | 1 | Writeback request flag |
| shamt | input | 2 | Left shift applied to the index value |
| rf_ra_addr | output | 4 | Read port A register number (base) |
| rf_ra_data | input | 32 | Read port A data |
| rf_rb_addr | output | 4 | Read port B register number (index) |
| rf_rb_data | input | 32 | Read port B data |
| mem_req_valid | output | 1 | Halfword read request valid |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_addr | output | 32 | Byte address of the halfword |
| mem_rsp_valid | input | 1 | Response data valid |
| mem_rsp_data | input | 16 | Returned halfword |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| redirect | output | 1 | Redirect to the unprivileged-load variant (valid with done) |
| unpred | output | 1 | Unpredictable register combination (valid with done) |
| wr0_en | output | 1 | Destination write enable |
| wr0_addr | output | 4 | Destination write register number |
| wr0_data | output | 32 | Sign-extended loaded value |
| wr1_en | output | 1 | Base write enable |
| wr1_addr | output | 4 | Base write register number |
| wr1_data | output | 32 | Offset address written back |

## Verification
The request address is due in the first cycle after the start edge. It must stay unchanged for as many cycles as ready is held low. The done pulse, both write ports and the two flags are due exactly one cycle after the edge that takes the response. For a redirected operation, they are due one cycle after the start edge. The bench drives every input on the falling edge, counts the edges between stimulus and result, and samples each output in the one cycle where it is due. It also checks that done has dropped again on the next cycle.

// File: rtl/hsload_pkg.sv
package hsload_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_WB    = 2'd3
  } hs_state_e;

  typedef enum logic [1:0] {
    VAR_FULL    = 2'b00,
    VAR_COMPACT = 2'b01,
    VAR_WIDE    = 2'b10,
    VAR_ALT     = 2'b11
  } hs_variant_e;

endpackage

// File: rtl/hsload_ctrl.sv
module hsload_ctrl #(
  parameter int RW  = 4,
  parameter int SHW = 2
) (
  input  logic [1:0]     variant,
  input  logic [RW-1:0]  dst_reg,
  input  logic [RW-1:0]  base_reg,
  input  logic [RW-1:0]  idx_reg,
  input  logic           pre_idx,
  input  logic           add_sel,
  input  logic           wb_sel,
  input  logic [SHW-1:0] shamt,
  output logic           eff_pre,
  output logic           eff_add,
  output logic [SHW-1:0] eff_sh,
  output logic           redir,
  output logic           unp,
  output logic           wr_base
);
  import hsload_pkg::*;

  localparam logic [RW-1:0] PC_REG = {RW{1'b1}};

  logic eff_wb;
  logic wback;

  always_comb begin
    eff_pre = pre_idx;
    eff_add = add_sel;
    eff_wb  = wb_sel;
    eff_sh  = shamt;
    case (hs_variant_e'(variant))
      VAR_COMPACT: begin
        eff_pre = 1'b1;
        eff_add = 1'b1;
        eff_wb  = 1'b0;
        eff_sh  = '0;
      end
      VAR_WIDE: begin
        eff_pre = 1'b1;
        eff_add = 1'b1;
        eff_wb  = 1'b0;
      end
      default: ;
    endcase
  end

  always_comb begin
    wback   = !eff_pre || eff_wb;
    redir   = !eff_pre && eff_wb;
    unp     = (dst_reg == PC_REG) || (idx_reg == PC_REG) ||
              (wback && ((base_reg == PC_REG) || (base_reg == dst_reg)));
    wr_base = wback && (base_reg != dst_reg);
  end

endmodule

// File: rtl/hsload_agen.sv
module hsload_agen #(
  parameter int XLEN = 32,
  parameter int SHW  = 2
) (
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] idx_val,
  input  logic [SHW-1:0]  sh,
  input  logic            add_sel,
  input  logic            pre_idx,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] off_addr
);

  logic [XLEN-1:0] stage [SHW+1];

  assign stage[0] = idx_val;

  for (genvar g = 0; g < SHW; g++) begin : g_shift
    assign stage[g+1] = sh[g] ? (stage[g] << (1 << g)) : stage[g];
  end

  always_comb begin
    off_addr = add_sel ? (base_val + stage[SHW]) : (base_val - stage[SHW]);
    mem_addr = pre_idx ? off_addr : base_val;
  end

endmodule

// File: rtl/hsload_seq.sv
module hsload_seq #(
  parameter int XLEN = 32,
  parameter int HW   = 16,
  parameter int RW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            redir_i,
  input  logic            unp_i,
  input  logic            wrbase_i,
  input  logic [RW-1:0]   dst_i,
  input  logic [RW-1:0]   base_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [XLEN-1:0] off_i,
  input  logic            mem_req_ready,
  input  logic            mem_rsp_valid,
  input  logic [HW-1:0]   mem_rsp_data,
  output logic            mem_req_valid,
  output logic [XLEN-1:0] mem_req_addr,
  output logic            busy,
  output logic            done,
  output logic            redirect,
  output logic            unpred,
  output logic            wr0_en,
  output logic [RW-1:0]   wr0_addr,
  output logic [XLEN-1:0] wr0_data,
  output logic            wr1_en,
  output logic [RW-1:0]   wr1_addr,
  output logic [XLEN-1:0] wr1_data
);
  import hsload_pkg::*;

  localparam int EXT = XLEN - HW;

  hs_state_e       state_q, state_d;
  logic [XLEN-1:0] addr_q, off_q;
  logic [RW-1:0]   dst_q, base_q;
  logic            redir_q, unp_q, wrbase_q;
  logic [HW-1:0]   data_q;
  logic            cap_en, rsp_en;

  assign cap_en = start && (state_q == ST_IDLE);
  assign rsp_en = mem_rsp_valid && (state_q == ST_WAIT);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = redir_i ? ST_WB : ST_ISSUE;
      ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) state_d = ST_WB;
      ST_WB:    state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      off_q    <= '0;
      dst_q    <= '0;
      base_q   <= '0;
      redir_q  <= 1'b0;
      unp_q    <= 1'b0;
      wrbase_q <= 1'b0;
    end else if (cap_en) begin
      addr_q   <= addr_i;
      off_q    <= off_i;
      dst_q    <= dst_i;
      base_q   <= base_i;
      redir_q  <= redir_i;
      unp_q    <= unp_i;
      wrbase_q <= wrbase_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (rsp_en) data_q <= mem_rsp_data;
  end

  always_comb begin
    busy          = (state_q != ST_IDLE);
    mem_req_valid = (state_q == ST_ISSUE);
    mem_req_addr  = addr_q;
    done          = (state_q == ST_WB);
    redirect      = done && redir_q;
    unpred        = done && unp_q;
    wr0_en        = done && !redir_q;
    wr0_addr      = dst_q;
    wr0_data      = {{EXT{data_q[HW-1]}}, data_q};
    wr1_en        = done && !redir_q && wrbase_q;
    wr1_addr      = base_q;
    wr1_data      = off_q;
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_rsp_to_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_req_valid && !done && mem_rsp_valid) |=> done);

  assert_base_with_dest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr1_en |-> wr0_en);

  assert_redirect_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (done && !wr0_en && !wr1_en));

  assert_redirect_noreq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && redir_i) |=> (done && !mem_req_valid));

  assert_distinct_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr1_en |-> (wr1_addr != wr0_addr));

endmodule

// File: rtl/hsload_unit.sv
module hsload_unit #(
  parameter int XLEN = 32,
  parameter int HW   = 16,
  parameter int RW   = 4,
  parameter int SHW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      variant,
  input  logic [RW-1:0]   dst_reg,
  input  logic [RW-1:0]   base_reg,
  input  logic [RW-1:0]   idx_reg,
  input  logic            pre_idx,
  input  logic            add_sel,
  input  logic            wb_sel,
  input  logic [SHW-1:0]  shamt,
  output logic [RW-1:0]   rf_ra_addr,
  input  logic [XLEN-1:0] rf_ra_data,
  output logic [RW-1:0]   rf_rb_addr,
  input  logic [XLEN-1:0] rf_rb_data,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [HW-1:0]   mem_rsp_data,
  output logic            busy,
  output logic            done,
  output logic            redirect,
  output logic            unpred,
  output logic            wr0_en,
  output logic [RW-1:0]   wr0_addr,
  output logic [XLEN-1:0] wr0_data,
  output logic            wr1_en,
  output logic [RW-1:0]   wr1_addr,
  output logic [XLEN-1:0] wr1_data
);

  logic            rst_meta_q, rst_sync_q;
  logic            eff_pre, eff_add, redir, unp, wr_base;
  logic [SHW-1:0]  eff_sh;
  logic [XLEN-1:0] addr_c, off_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign rf_ra_addr = base_reg;
  assign rf_rb_addr = idx_reg;

  hsload_ctrl #(.RW(RW), .SHW(SHW)) u_ctrl (
    .variant  (variant),
    .dst_reg  (dst_reg),
    .base_reg (base_reg),
    .idx_reg  (idx_reg),
    .pre_idx  (pre_idx),
    .add_sel  (add_sel),
    .wb_sel   (wb_sel),
    .shamt    (shamt),
    .eff_pre  (eff_pre),
    .eff_add  (eff_add),
    .eff_sh   (eff_sh),
    .redir    (redir),
    .unp      (unp),
    .wr_base  (wr_base)
  );

  hsload_agen #(.XLEN(XLEN), .SHW(SHW)) u_agen (
    .base_val (rf_ra_data),
    .idx_val  (rf_rb_data),
    .sh       (eff_sh),
    .add_sel  (eff_add),
    .pre_idx  (eff_pre),
    .mem_addr (addr_c),
    .off_addr (off_c)
  );

  hsload_seq #(.XLEN(XLEN), .HW(HW), .RW(RW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_sync_q),
    .start         (start),
    .redir_i       (redir),
    .unp_i         (unp),
    .wrbase_i      (wr_base),
    .dst_i         (dst_reg),
    .base_i        (base_reg),
    .addr_i        (addr_c),
    .off_i         (off_c),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .busy          (busy),
    .done          (done),
    .redirect      (redirect),
    .unpred        (unpred),
    .wr0_en        (wr0_en),
    .wr0_addr      (wr0_addr),
    .wr0_data      (wr0_data),
    .wr1_en        (wr1_en),
    .wr1_addr      (wr1_addr),
    .wr1_data      (wr1_data)
  );

endmodule

// File: tb/hsload_unit_bench.sv
module hsload_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  variant;
  logic [3:0]  dst_reg, base_reg, idx_reg;
  logic        pre_idx, add_sel, wb_sel;
  logic [1:0]  shamt;
  logic [3:0]  rf_ra_addr, rf_rb_addr;
  logic [31:0] rf_ra_data, rf_rb_data;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [15:0] mem_rsp_data;
  logic        busy, done, redirect, unpred;
  logic        wr0_en, wr1_en;
  logic [3:0]  wr0_addr, wr1_addr;
  logic [31:0] wr0_data, wr1_data;

  logic [31:0] regs [16];
  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  assign rf_ra_data = regs[rf_ra_addr];
  assign rf_rb_data = regs[rf_rb_addr];

  hsload_unit u_hsload_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .variant(variant),
    .dst_reg(dst_reg), .base_reg(base_reg), .idx_reg(idx_reg),
    .pre_idx(pre_idx), .add_sel(add_sel), .wb_sel(wb_sel), .shamt(shamt),
    .rf_ra_addr(rf_ra_addr), .rf_ra_data(rf_ra_data),
    .rf_rb_addr(rf_rb_addr), .rf_rb_data(rf_rb_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .busy(busy), .done(done),
    .redirect(redirect), .unpred(unpred),
    .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      tests++;
      fails++;
      $display("FAIL watchdog R11: actual %0d cycles expected below 20000", cycles);
      finish_run();
    end
  end

  // One load: drives fields, models memory with given delays, checks all results.
  task automatic run_op(input string tag, input logic [1:0] v, input logic [3:0] d,
                        input logic [3:0] b, input logic [3:0] x, input logic p,
                        input logic a, input logic w, input logic [1:0] s,
                        input int rdly, input int sdly, input logic [15:0] hw);
    logic        ep, ea, ew, wbk, rdr, unp, wrb;
    logic [1:0]  es;
    logic [31:0] offv, offa, addr, ext;
    ep = p; ea = a; ew = w; es = s;
    if (v == 2'b01) begin ep = 1; ea = 1; ew = 0; es = 0; end
    if (v == 2'b10) begin ep = 1; ea = 1; ew = 0; end
    offv = regs[x] << es;
    offa = ea ? regs[b] + offv : regs[b] - offv;
    addr = ep ? offa : regs[b];
    wbk  = !ep || ew;
    rdr  = !ep && ew;
    unp  = (d == 15) || (x == 15) || (wbk && ((b == 15) || (b == d)));
    wrb  = wbk && (b != d);
    ext  = {{16{hw[15]}}, hw};

    @(negedge clk);
    start = 1; variant = v; dst_reg = d; base_reg = b; idx_reg = x;
    pre_idx = p; add_sel = a; wb_sel = w; shamt = s;
    @(negedge clk);
    start = 0;
    if (!rdr) begin
      chk(mem_req_valid === 1'b1, {tag, " R10 request after start"}, 32'(mem_req_valid), 1);
      chk(mem_req_addr === addr, {tag, " R1 R2 R3 R12 request address"}, mem_req_addr, addr);
      for (int i = 0; i < rdly; i++) begin
        @(negedge clk);
        chk(mem_req_valid === 1'b1 && mem_req_addr === addr,
            {tag, " R10 held while not ready"}, mem_req_addr, addr);
      end
      mem_req_ready = 1;
      @(negedge clk);
      mem_req_ready = 0;
      chk(mem_req_valid === 1'b0, {tag, " R10 single request"}, 32'(mem_req_valid), 0);
      for (int i = 0; i < sdly; i++) begin
        @(negedge clk);
        chk(done === 1'b0, {tag, " R11 no early done"}, 32'(done), 0);
      end
      mem_rsp_valid = 1; mem_rsp_data = hw;
      @(negedge clk);
      mem_rsp_valid = 0; mem_rsp_data = 16'hxxxx;
    end else begin
      chk(mem_req_valid === 1'b0, {tag, " R6 no request"}, 32'(mem_req_valid), 0);
    end
    chk(done === 1'b1, {tag, " R6 R11 done due"}, 32'(done), 1);
    chk(redirect === rdr, {tag, " R6 R9 redirect flag"}, 32'(redirect), 32'(rdr));
    chk(unpred === unp, {tag, " R7 R8 unpredictable flag"}, 32'(unpred), 32'(unp));
    chk(wr0_en === !rdr, {tag, " R6 R11 destination write enable"}, 32'(wr0_en), 32'(!rdr));
    if (!rdr) begin
      chk(wr0_addr === d, {tag, " R5 destination number"}, 32'(wr0_addr), 32'(d));
      chk(wr0_data === ext, {tag, " R5 sign-extended data"}, wr0_data, ext);
    end
    chk(wr1_en === (wrb && !rdr), {tag, " R4 R8 base write enable"}, 32'(wr1_en),
        32'(wrb && !rdr));
    if (wrb && !rdr) begin
      chk(wr1_addr === b, {tag, " R4 base number"}, 32'(wr1_addr), 32'(b));
      chk(wr1_data === offa, {tag, " R4 written-back offset address"}, wr1_data, offa);
    end
    @(negedge clk);
    chk(done === 1'b0 && wr0_en === 1'b0 && wr1_en === 1'b0,
        {tag, " R11 done one cycle"}, 32'(done), 0);
  endtask

  task automatic t_reset();
    chk(mem_req_valid === 1'b0, "reset R10 no request", 32'(mem_req_valid), 0);
    chk(done === 1'b0 && busy === 1'b0, "reset R11 idle", 32'(done), 0);
    chk(wr0_en === 1'b0 && wr1_en === 1'b0, "reset R11 no writes", 32'(wr0_en), 0);
  endtask

  task automatic t_basic();
    run_op("basic add", 2'b00, 4'd1, 4'd2, 4'd3, 1, 1, 0, 2'd0, 0, 0, 16'h1234);
    run_op("sub shift3 neg", 2'b00, 4'd4, 4'd2, 4'd3, 1, 0, 0, 2'd3, 1, 2, 16'h8001);
  endtask

  task automatic t_shifts();
    run_op("shift1 R1", 2'b00, 4'd5, 4'd6, 4'd7, 1, 1, 0, 2'd1, 0, 1, 16'h7FFF);
    run_op("shift2 R1", 2'b00, 4'd5, 4'd6, 4'd7, 1, 1, 0, 2'd2, 2, 0, 16'hFFFF);
  endtask

  task automatic t_writeback();
    run_op("pre wb", 2'b00, 4'd1, 4'd2, 4'd3, 1, 1, 1, 2'd1, 0, 0, 16'hC0DE);
    run_op("post sub", 2'b00, 4'd8, 4'd2, 4'd3, 0, 0, 0, 2'd2, 3, 1, 16'h0042);
  endtask

  task automatic t_redirect();
    run_op("redirect R6", 2'b00, 4'd1, 4'd2, 4'd3, 0, 1, 1, 2'd0, 0, 0, 16'h0000);
  endtask

  task automatic t_unpred();
    run_op("dest15 R7", 2'b00, 4'd15, 4'd2, 4'd3, 1, 1, 0, 2'd0, 0, 0, 16'h9000);
    run_op("idx15 R7", 2'b00, 4'd1, 4'd2, 4'd15, 1, 1, 0, 2'd0, 0, 0, 16'h0001);
    run_op("base eq dest R8", 2'b00, 4'd2, 4'd2, 4'd3, 1, 1, 1, 2'd0, 0, 0, 16'hABCD);
    run_op("base15 wb R8", 2'b00, 4'd1, 4'd15, 4'd3, 0, 1, 0, 2'd0, 1, 0, 16'h5555);
    run_op("base eq dest no wb R8", 2'b00, 4'd2, 4'd2, 4'd3, 1, 1, 0, 2'd0, 0, 0, 16'h1111);
  endtask

  task automatic t_variants();
    run_op("compact R9", 2'b01, 4'd1, 4'd2, 4'd3, 0, 0, 1, 2'd3, 0, 0, 16'hF00F);
    run_op("wide R9", 2'b10, 4'd1, 4'd2, 4'd3, 0, 0, 1, 2'd2, 1, 1, 16'h0F0F);
  endtask

  task automatic t_wrap();
    run_op("wrap odd R12", 2'b00, 4'd1, 4'd9, 4'd10, 1, 1, 1, 2'd0, 0, 0, 16'h8000);
    run_op("underflow R12", 2'b00, 4'd1, 4'd10, 4'd11, 0, 0, 0, 2'd1, 0, 0, 16'h7F80);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h0001_0000 + 32'(i) * 32'h111;
    regs[2]  = 32'h0000_1000;
    regs[3]  = 32'h0000_0020;
    regs[6]  = 32'h2000_0000;
    regs[7]  = 32'h0000_0013;
    regs[9]  = 32'hFFFF_FFFE;
    regs[10] = 32'h0000_0005;
    regs[11] = 32'h0000_0004;
    regs[15] = 32'h0000_8000;
    rst_n = 0; start = 0; variant = 0; dst_reg = 0; base_reg = 0; idx_reg = 0;
    pre_idx = 0; add_sel = 0; wb_sel = 0; shamt = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_shifts();
    t_writeback();
    t_redirect();
    t_unpred();
    t_variants();
    t_wrap();
    finish_run();
  end

endmodule